// File: doc/BRIEF.md
# Odd/Even Buffer Dump Transmitter

After reset the block fills a two-port memory with the count 0 to N_VAL-1. Each port takes one half of the addresses, and both ports write in the same clock. The block then scans the memory once through both ports. Values with the lowest bit set are taken from the first port into an odd buffer. Values with the lowest bit clear are taken from the second port into an even buffer. Each buffer holds N_VAL/2 entries.

Two active-low push-buttons are debounced, and each one starts the playback of one buffer. A playback sends the buffer, in ascending order, as a run of UART frames on one serial line. The two playback sequencers share a single transmitter. An arbiter lets only one of them own the transmitter's start strobe and data byte at a time. Each next byte is requested by the transmitter's end-of-frame pulse.

Top module: `oddeven_uart_dump`

## Requirements
- R1: After a press of the odd key (lane 0), the line carries N_VAL/2 frames whose bytes are 1, 3, 5, ... N_VAL-1, in ascending order.
- R2: After a press of the even key (lane 1), the line carries N_VAL/2 frames whose bytes are 0, 2, 4, ... N_VAL-2, in ascending order.
- R3: A frame has 11 slots of CLK_HZ/BAUD clock cycles each: slot 0 is low (start), slots 1 to 8 carry the data LSB first, slot 9 is parity and slot 10 is high (stop). The line does not change inside a slot.
- R4: The parity slot is the XOR of the 8 data bits when PAR_ODD=0, and its inverse when PAR_ODD=1.
- R5: The line is high from reset on, and at every time when no frame is being sent.
- R6: A key held low for fewer than DEB_DELAY-2 consecutive cycles starts nothing. Releasing the key clears its count, so two short presses do not add up.
- R7: Within one dump, the line stays high for exactly 3 clock cycles between the last stop-bit cycle of one frame and the start bit of the next.
- R8: A press of the other key while a dump is running is dropped, not queued. No frames follow once the running dump ends.
- R9: A key held low for many debounce periods starts exactly one dump.
- R10: A second press of the same key after a dump has ended sends the same buffer content again.
- R11: When both keys are recognised in the same cycle, only the odd dump is sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| key_odd_ni | input | 1 | Key that starts the odd dump, active low |
| key_even_ni | input | 1 | Key that starts the even dump, active low |
| tx_o | output | 1 | Serial line, idles high |

## Verification
The bench builds the block with DEB_DELAY=8, CLK_HZ=1600 and BAUD=100. This gives 16 cycles per bit, so four complete 50-frame dumps fit well inside the run time. The short debounce makes the under-length glitch and the release-clears case quick to reach. The bench sets PAR_ODD=1, so the inverted parity path is the one checked. Keeping the default N_VAL=100 exercises the full fill, the full scan and the last-address turnaround of both playback sequencers.

// File: rtl/oed_pkg.sv
package oed_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_FILL = 2'd1,
    SQ_ARM  = 2'd2,
    SQ_SEND = 2'd3
  } sq_state_e;

  localparam int unsigned LANES    = 2;
  localparam int unsigned LANE_ODD = 0;
  localparam int unsigned LANE_EVN = 1;
endpackage

// File: rtl/oed_debounce.sv
module oed_debounce #(
  parameter int unsigned DELAY = 1_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic key_ni,
  output logic hit_o
);
  localparam int unsigned CW = $clog2(DELAY);
  localparam logic [CW-1:0] SAT = CW'(DELAY - 1);
  localparam logic [CW-1:0] HIT = CW'(DELAY - 2);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (key_ni)       cnt_q <= '0;
    else if (cnt_q != SAT) cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o = (cnt_q == HIT);

  AST_HIT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> !hit_o); // R9
endmodule

// File: rtl/oed_source.sv
module oed_source #(
  parameter int unsigned N_VAL  = 100,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              odd_vld_o,
  output logic [DATA_W-1:0] odd_data_o,
  output logic              evn_vld_o,
  output logic [DATA_W-1:0] evn_data_o
);
  localparam int unsigned AW   = $clog2(N_VAL);
  localparam int unsigned HALF = N_VAL / 2;
  localparam logic [AW-1:0] K_LAST = AW'(HALF - 1);
  localparam logic [AW-1:0] J_LAST = AW'(N_VAL - 1);

  logic [DATA_W-1:0] mem_q [N_VAL];
  logic              fill_q, scan_q, rd_vld_q;
  logic [AW-1:0]     fill_k_q, scan_j_q;
  logic [AW-1:0]     wa_a, wa_b;
  logic [DATA_W-1:0] rd_a_q, rd_b_q;
  logic              odd_vld_q, evn_vld_q;
  logic [DATA_W-1:0] odd_q, evn_q;

  // port A takes even addresses, port B odd ones, same clock
  assign wa_a = {fill_k_q[AW-2:0], 1'b0};
  assign wa_b = {fill_k_q[AW-2:0], 1'b1};

  always_ff @(posedge clk_i) begin
    if (fill_q) begin
      mem_q[wa_a] <= DATA_W'(wa_a);
      mem_q[wa_b] <= DATA_W'(wa_b);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q   <= 1'b1;
      scan_q   <= 1'b0;
      fill_k_q <= '0;
      scan_j_q <= '0;
    end else if (fill_q) begin
      if (fill_k_q == K_LAST) begin
        fill_q <= 1'b0;
        scan_q <= 1'b1;
      end else begin
        fill_k_q <= fill_k_q + 1'b1;
      end
    end else if (scan_q) begin
      if (scan_j_q == J_LAST) scan_q <= 1'b0;
      else                    scan_j_q <= scan_j_q + 1'b1;
    end
  end

  // two read ports on the same scan address
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_vld_q <= 1'b0;
      rd_a_q   <= '0;
      rd_b_q   <= '0;
    end else begin
      rd_vld_q <= scan_q;
      if (scan_q) begin
        rd_a_q <= mem_q[scan_j_q];
        rd_b_q <= mem_q[scan_j_q];
      end
    end
  end

  // parity filter: hold last capture when the lsb does not match
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      odd_vld_q <= 1'b0;
      evn_vld_q <= 1'b0;
      odd_q     <= '0;
      evn_q     <= '0;
    end else begin
      odd_vld_q <= rd_vld_q & rd_a_q[0];
      evn_vld_q <= rd_vld_q & ~rd_b_q[0];
      if (rd_vld_q && rd_a_q[0])  odd_q <= rd_a_q;
      if (rd_vld_q && !rd_b_q[0]) evn_q <= rd_b_q;
    end
  end

  assign odd_vld_o  = odd_vld_q;
  assign odd_data_o = odd_q;
  assign evn_vld_o  = evn_vld_q;
  assign evn_data_o = evn_q;

  AST_ODD_LSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    odd_vld_o |-> odd_data_o[0]); // R1
  AST_EVN_LSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evn_vld_o |-> !evn_data_o[0]); // R2
endmodule

// File: rtl/oed_seq.sv
module oed_seq
  import oed_pkg::*;
#(
  parameter int unsigned DEPTH  = 50,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_vld_i,
  input  logic [DATA_W-1:0] cap_data_i,
  input  logic              go_i,
  input  logic              done_i,
  output logic              idle_o,
  output logic              busy_o,
  output logic              start_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned PW = $clog2(DEPTH);
  localparam logic [PW-1:0] P_LAST = PW'(DEPTH - 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  sq_state_e         state_q;
  logic [PW-1:0]     wr_ptr_q, rd_addr_q;
  logic              start_q;

  always_ff @(posedge clk_i) begin
    if (state_q == SQ_FILL && cap_vld_i) mem_q[wr_ptr_q] <= cap_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= SQ_FILL;
      wr_ptr_q  <= '0;
      rd_addr_q <= '0;
      start_q   <= 1'b0;
    end else begin
      start_q <= 1'b0;
      unique case (state_q)
        SQ_FILL: begin
          if (cap_vld_i) begin
            if (wr_ptr_q == P_LAST) state_q  <= SQ_IDLE;
            else                    wr_ptr_q <= wr_ptr_q + 1'b1;
          end
        end
        SQ_IDLE: if (go_i) state_q <= SQ_ARM;
        SQ_ARM: begin
          rd_addr_q <= '0;
          start_q   <= 1'b1;
          state_q   <= SQ_SEND;
        end
        SQ_SEND: begin
          if (done_i) begin
            if (rd_addr_q == P_LAST) begin
              state_q <= SQ_IDLE;
            end else begin
              rd_addr_q <= rd_addr_q + 1'b1;
              start_q   <= 1'b1;
            end
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign idle_o  = (state_q == SQ_IDLE);
  assign busy_o  = (state_q == SQ_ARM) || (state_q == SQ_SEND);
  assign start_o = start_q;
  assign data_o  = mem_q[rd_addr_q];

  AST_ADDR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(rd_addr_q) < DEPTH); // R1
  AST_START_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_q && state_q == SQ_SEND && $past(state_q) == SQ_SEND) |-> $past(done_i)); // R7
endmodule

// File: rtl/oed_uart_tx.sv
module oed_uart_tx #(
  parameter int unsigned CLK_HZ  = 50_000_000,
  parameter int unsigned BAUD    = 115_200,
  parameter int unsigned DATA_W  = 8,
  parameter bit          PAR_ODD = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              tx_o,
  output logic              done_o
);
  localparam int unsigned PER   = CLK_HZ / BAUD;
  localparam int unsigned CW    = $clog2(PER);
  localparam int unsigned SLOTS = DATA_W + 3;
  localparam int unsigned SW    = $clog2(SLOTS);
  localparam logic [CW-1:0] C_LAST  = CW'(PER - 1);
  localparam logic [SW-1:0] S_FIRST = SW'(1);
  localparam logic [SW-1:0] S_DLAST = SW'(DATA_W);
  localparam logic [SW-1:0] S_PAR   = SW'(DATA_W + 1);
  localparam logic [SW-1:0] S_STOP  = SW'(DATA_W + 2);

  logic              s1_q, s2_q, start_edge;
  logic              busy_q, par_q;
  logic [CW-1:0]     cnt_q;
  logic [SW-1:0]     slot_q;
  logic [DATA_W-1:0] sh_q;

  assign start_edge = s1_q & ~s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      busy_q <= 1'b0;
      par_q  <= 1'b0;
      cnt_q  <= '0;
      slot_q <= '0;
      sh_q   <= '0;
    end else begin
      s1_q <= start_i;
      s2_q <= s1_q;
      if (!busy_q) begin
        if (start_edge) begin
          busy_q <= 1'b1;
          cnt_q  <= '0;
          slot_q <= '0;
          sh_q   <= data_i;            // latched once, immune to later changes
          par_q  <= (^data_i) ^ PAR_ODD;
        end
      end else if (cnt_q == C_LAST) begin
        cnt_q <= '0;
        if (slot_q == S_STOP) busy_q <= 1'b0;
        else                  slot_q <= slot_q + 1'b1;
        if (slot_q >= S_FIRST && slot_q <= S_DLAST) sh_q <= sh_q >> 1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    tx_o = 1'b1;
    if (busy_q) begin
      if (slot_q == '0)         tx_o = 1'b0;
      else if (slot_q <= S_DLAST) tx_o = sh_q[0];
      else if (slot_q == S_PAR) tx_o = par_q;
    end
  end

  assign done_o = busy_q && (slot_q == S_STOP) && (cnt_q == C_LAST);

  AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_edge |-> !busy_q); // R7
  AST_DONE_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_q); // R3
  AST_SLOT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q != C_LAST) |=> $stable(slot_q) && $stable(tx_o)); // R3
  AST_IDLE_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !start_edge) |=> tx_o); // R5
endmodule

// File: rtl/oddeven_uart_dump.sv
module oddeven_uart_dump
  import oed_pkg::*;
#(
  parameter int unsigned N_VAL     = 100,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned DEB_DELAY = 1_000_000,
  parameter int unsigned CLK_HZ    = 50_000_000,
  parameter int unsigned BAUD      = 115_200,
  parameter bit          PAR_ODD   = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic key_odd_ni,
  input  logic key_even_ni,
  output logic tx_o
);
  localparam int unsigned DEPTH = N_VAL / 2;

  logic [LANES-1:0]             key_n, hit, idle, busy, start, go, cap_vld;
  logic [LANES-1:0][DATA_W-1:0] cap_data, rd_data;
  logic                         go_odd, go_evn;
  logic                         tx_start_q, tx_done;
  logic [DATA_W-1:0]            tx_data_q;

  assign key_n[LANE_ODD] = key_odd_ni;
  assign key_n[LANE_EVN] = key_even_ni;

  oed_source #(.N_VAL(N_VAL), .DATA_W(DATA_W)) u_source (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .odd_vld_o  (cap_vld[LANE_ODD]),
    .odd_data_o (cap_data[LANE_ODD]),
    .evn_vld_o  (cap_vld[LANE_EVN]),
    .evn_data_o (cap_data[LANE_EVN])
  );

  // one lane may start only when the other owns nothing; odd wins a tie
  assign go_odd = hit[LANE_ODD] & idle[LANE_ODD] & ~busy[LANE_EVN];
  assign go_evn = hit[LANE_EVN] & idle[LANE_EVN] & ~busy[LANE_ODD] & ~go_odd;
  assign go[LANE_ODD] = go_odd;
  assign go[LANE_EVN] = go_evn;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    oed_debounce #(.DELAY(DEB_DELAY)) u_deb (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .key_ni (key_n[g]),
      .hit_o  (hit[g])
    );

    oed_seq #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_seq (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cap_vld_i  (cap_vld[g]),
      .cap_data_i (cap_data[g]),
      .go_i       (go[g]),
      .done_i     (tx_done),
      .idle_o     (idle[g]),
      .busy_o     (busy[g]),
      .start_o    (start[g]),
      .data_o     (rd_data[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_start_q <= 1'b0;
      tx_data_q  <= '0;
    end else if (busy[LANE_ODD]) begin
      tx_start_q <= start[LANE_ODD];
      tx_data_q  <= rd_data[LANE_ODD];
    end else if (busy[LANE_EVN]) begin
      tx_start_q <= start[LANE_EVN];
      tx_data_q  <= rd_data[LANE_EVN];
    end
  end

  oed_uart_tx #(
    .CLK_HZ  (CLK_HZ),
    .BAUD    (BAUD),
    .DATA_W  (DATA_W),
    .PAR_ODD (PAR_ODD)
  ) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (tx_start_q),
    .data_i  (tx_data_q),
    .tx_o    (tx_o),
    .done_o  (tx_done)
  );

  AST_ONE_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy[LANE_ODD] && busy[LANE_EVN])); // R8
  AST_TIE_ODD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit[LANE_ODD] && hit[LANE_EVN] && idle[LANE_ODD] && idle[LANE_EVN])
      |=> busy[LANE_ODD] && !busy[LANE_EVN]); // R11
endmodule

// File: tb/oddeven_uart_dump_bench.sv
`timescale 1ns/1ps
module oddeven_uart_dump_bench;
  localparam int DLY     = 8;
  localparam int CLK_HZ  = 1600;
  localparam int BAUD    = 100;
  localparam int PER     = CLK_HZ / BAUD;
  localparam int NV      = 100;
  localparam bit PAR_ODD = 1'b1;

  logic clk = 1'b0, rst_n = 1'b0, key_o = 1'b1, key_e = 1'b1;
  logic tx;

  always #5 clk = ~clk;

  oddeven_uart_dump #(
    .N_VAL(NV), .DATA_W(8), .DEB_DELAY(DLY),
    .CLK_HZ(CLK_HZ), .BAUD(BAUD), .PAR_ODD(PAR_ODD)
  ) u_oddeven_uart_dump (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .key_odd_ni  (key_o),
    .key_even_ni (key_e),
    .tx_o        (tx)
  );

  int checks = 0, errors = 0, frames = 0, cyc = 0;
  int q_val[$];
  string q_tag[$];
  bit in_frame = 0, mid = 0;
  int fc = 0, gap = 0;
  logic [10:0] sv;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // reference receiver: checks every clock inside a frame, counts idle gaps
  always @(negedge clk) begin
    if (rst_n) begin
      if (!in_frame && tx == 1'b0) begin
        if (mid) chk(gap == 3, "R7", "idle cycles between frames", gap, 3);
        in_frame = 1;
        fc = 0;
      end else if (!in_frame) begin
        gap++;
      end
      if (in_frame) begin
        if (fc % PER == 0) sv[fc / PER] = tx;
        else if (tx != sv[fc / PER]) chk(0, "R3", "line changed inside slot", tx, sv[fc / PER]);
        fc++;
        if (fc == 11 * PER) begin
          logic [7:0] d;
          logic ep;
          d  = sv[8:1];
          ep = (^d) ^ PAR_ODD;
          frames++;
          chk(sv[10] == 1'b1, "R3", "stop bit", sv[10], 1);
          chk(sv[9] == ep, "R4", "parity bit", sv[9], ep);
          if (q_val.size() == 0) begin
            chk(0, "R8", "unexpected frame byte", d, -1);
          end else begin
            int v;
            string t;
            v = q_val.pop_front();
            t = q_tag.pop_front();
            chk(d == v[7:0], t, "frame byte", d, v);
          end
          mid = (q_val.size() > 0);
          in_frame = 0;
          gap = 0;
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      summary();
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(bit odd, string tag);
    for (int i = 0; i < NV / 2; i++) begin
      q_val.push_back(odd ? 2 * i + 1 : 2 * i);
      q_tag.push_back(tag);
    end
  endtask

  task automatic hold_key(bit odd, int n);
    if (odd) key_o = 1'b0;
    else     key_e = 1'b0;
    tick(n);
    key_o = 1'b1;
    key_e = 1'b1;
  endtask

  task automatic drain();
    while (q_val.size() != 0 || in_frame) tick(1);
    tick(200);
  endtask

  task automatic quiet(int n, string tag);
    int f0;
    f0 = frames;
    tick(n);
    chk(frames == f0, tag, "frames in quiet window", frames - f0, 0);
    chk(tx == 1'b1, "R5", "line idle level", tx, 1);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    chk(tx == 1'b1, "R5", "line after reset", tx, 1);
    quiet(300, "R5");

    // R6: two glitches one cycle short of a hit, separated by a release
    hold_key(1, DLY - 3);
    tick(1);
    hold_key(1, DLY - 3);
    quiet(400, "R6");

    // R1 with a long hold (R9); even key pressed mid-dump (R8)
    push(1, "R1");
    hold_key(1, 10 * DLY);
    while (frames < 5) tick(1);
    hold_key(0, 3 * DLY);
    drain();
    quiet(600, "R8");
    quiet(300, "R9");

    // R2
    push(0, "R2");
    hold_key(0, 2 * DLY);
    drain();

    // R10: replay of the odd buffer
    push(1, "R10");
    hold_key(1, 2 * DLY);
    drain();

    // R11: both keys in the same cycle
    push(1, "R11");
    key_o = 1'b0;
    key_e = 1'b0;
    tick(2 * DLY);
    key_o = 1'b1;
    key_e = 1'b1;
    drain();
    quiet(600, "R11");

    chk(q_val.size() == 0, "R1", "expected frames left", q_val.size(), 0);
    summary();
  end
endmodule